// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine takes an incoming frame as a byte stream and places it into host buffers that are described by a ring of receive descriptors. The descriptors sit in a small internal memory that the host fills and reads back through a simple port. The first byte of a frame carries a start marker and the last byte carries an end marker. For each frame the engine decides whether to keep it or drop it. It spreads a long frame over as many descriptors as it needs, hands each descriptor back to the host by clearing its ownership bit, and raises one-cycle receive-done and missed-frame events.

The buffer bytes leave the block on a byte write strobe. The strobe carries the descriptor index and the offset inside that buffer, so an outside memory can store them. The ring holds 2^E descriptors, where E is the upper three bits of the ring-length byte. The engine keeps the current descriptor index and wraps it with the mask 2^E-1.

The controller has five states:
- **IDLE** waits for a start-marked byte. It moves to **FILL** when the current descriptor is owned. It moves to **DROP** when the receiver is disabled or the descriptor belongs to the host.
- **FILL** stores bytes. It moves to **CLOSE** on the end marker and to **NEXT** when the buffer is full.
- **NEXT** inspects the following descriptor. It returns to **FILL** when that descriptor can take the rest of the frame, and otherwise moves to **DROP**.
- **CLOSE** writes the final descriptor back and returns to **IDLE**.
- **DROP** swallows bytes up to the end marker and then returns to **IDLE**.

Top module: `rxr_engine`

## Requirements
- R1: The ring holds 2^`ring_len[7:5]` descriptors and `ring_len[4:0]` is ignored. The descriptor index starts at 0 after reset and steps with the wrap (index+1) & (2^E-1).
- R2: A frame whose start byte arrives while `rx_en` is 0 is fully consumed. It produces no buffer write and no event, and leaves every descriptor unchanged.
- R3: A frame that starts while the current descriptor has `own`=0 is fully consumed. It produces no buffer write and raises `miss_evt` for exactly one cycle. The descriptor index does not move.
- R4: The first descriptor a frame uses is written back with `sop`=1. Every later descriptor of the same frame is written back with `sop`=0.
- R5: A descriptor's capacity is 4096 minus `neg_size`, with `neg_size` stored as the two's-complement negative byte count. Byte k of a buffer is written with `buf_off`=k and `buf_idx` set to that descriptor's index.
- R6: When the end byte lands in a buffer, including the byte that fills it, the descriptor is written back with `own`=0, `eop`=1 and `count` equal to the bytes stored. `rint_evt` pulses for one cycle, and the index advances.
- R7: A buffer that fills before the end byte is written back with `own`=0, `eop`=0 and `count` equal to its capacity. The frame then continues in the next descriptor, provided that descriptor is owned and is not the same entry.
- R8: If the next descriptor is host-owned, or the ring has one entry, the full buffer is written back with `own`=0, `buff`=1, `oflo`=1 and `eop`=0. `rint_evt` pulses, the index moves to the next entry, and the rest of the frame is dropped.
- R9: The descriptor word layout is: `own` in bit 31, `sop` in bit 30, `eop` in bit 29, `oflo` in bit 28, `buff` in bit 27, zero in bits 26:24, `neg_size` in bits 23:12 and `count` in bits 11:0.
- R10: `in_ready` is low for one cycle while a start byte is evaluated and for one cycle on every buffer change (NEXT). A byte offered in IDLE without a start marker is accepted and discarded.
- R11: `host_rdata` shows the descriptor at `host_addr` in the same cycle, and a `host_we` write is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| ring_len | input | 8 | Ring-length byte; bits 7:5 are the size exponent |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| host_we | input | 1 | Host descriptor write strobe |
| host_addr | input | 7 | Host descriptor index |
| host_wdata | input | 32 | Host descriptor write word |
| host_rdata | output | 32 | Descriptor word at host_addr |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_idx | output | 7 | Descriptor index of the buffer written |
| buf_off | output | 12 | Byte offset inside the buffer |
| buf_data | output | 8 | Byte written |
| rint_evt | output | 1 | One-cycle receive-done event |
| miss_evt | output | 1 | One-cycle missed-frame event |

## Verification
The bench targets several corner cases.

- **End byte on the last free slot.** A design that checked fullness before the end marker would chain into an extra descriptor and leave `eop` clear.
- **Chaining across the ring wrap.** A wrong mask would write past the last descriptor.
- **Ring of one entry.** A design that did not treat this as overflow would chain into the descriptor it just gave back and overwrite it.
- **Overflow into a host-owned descriptor.** A design that got this wrong would set the error flags on the wrong descriptor or keep storing bytes.
- **Capacity-one buffers.** These expose an off-by-one in the negated count.

For every case, the number of stall cycles is compared against the count implied by each buffer change.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
    localparam int LEN_W = 12;
    localparam int EXP_W = 3;
    localparam int IDX_W = (1 << EXP_W) - 1;

    typedef struct packed {
        logic             own;
        logic             sop;
        logic             eop;
        logic             oflo;
        logic             buff;
        logic [2:0]       rsvd;
        logic [LEN_W-1:0] neg_size;
        logic [LEN_W-1:0] count;
    } rx_desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_NEXT,
        ST_CLOSE,
        ST_DROP
    } rx_state_t;
endpackage

// File: rtl/rxr_desc_mem.sv
`timescale 1ns/1ps
module rxr_desc_mem
    import rxr_pkg::*;
#(
    parameter int AW = rxr_pkg::IDX_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  rx_desc_t      host_wdata,
    output rx_desc_t      host_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  rx_desc_t      eng_wdata,
    input  logic [AW-1:0] eng_raddr,
    output rx_desc_t      eng_rdata
);
    rx_desc_t slots [DEPTH];

    // Engine write is issued last so it wins a same-entry collision.
    always_ff @(posedge clk) begin
        if (host_we) slots[host_addr] <= host_wdata;
        if (eng_we)  slots[eng_waddr] <= eng_wdata;
    end

    assign host_rdata = slots[host_addr];
    assign eng_rdata  = slots[eng_raddr];
endmodule

// File: rtl/rxr_ring_idx.sv
`timescale 1ns/1ps
module rxr_ring_idx #(
    parameter int EW = rxr_pkg::EXP_W,
    localparam int AW = (1 << EW) - 1
) (
    input  logic [EW-1:0] ring_exp,
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt,
    output logic          single
);
    logic [AW-1:0] mask;

    always_comb begin
        mask   = AW'((32'd1 << ring_exp) - 32'd1);
        nxt    = (cur + AW'(1)) & mask;
        single = (ring_exp == '0);
    end
endmodule

// File: rtl/rxr_ctrl.sv
`timescale 1ns/1ps
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW = rxr_pkg::IDX_W,
    parameter int LW = rxr_pkg::LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic          in_ready,
    input  rx_desc_t      rd_desc,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output rx_desc_t      wr_desc,
    input  logic [AW-1:0] idx_nxt,
    input  logic          idx_single,
    output logic [AW-1:0] idx,
    output logic          buf_we,
    output logic [AW-1:0] buf_idx,
    output logic [LW-1:0] buf_off,
    output logic [7:0]    buf_data,
    output logic          rint_evt,
    output logic          miss_evt
);
    rx_state_t     state, nstate;
    logic [LW:0]   cnt, cap;
    logic [LW-1:0] neg_q;
    logic          sop_q;
    logic          load_first, load_next, adv_idx, set_rint, set_miss;
    logic          unused_desc_bits;

    assign unused_desc_bits = ^{rd_desc.sop, rd_desc.eop, rd_desc.oflo,
                                rd_desc.buff, rd_desc.rsvd, rd_desc.count};

    function automatic logic [LW:0] cap_of(input logic [LW-1:0] neg);
        return (LW+1)'(1 << LW) - {1'b0, neg};
    endfunction

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            cnt      <= '0;
            cap      <= '0;
            neg_q    <= '0;
            sop_q    <= 1'b0;
            rint_evt <= 1'b0;
            miss_evt <= 1'b0;
        end else begin
            state    <= nstate;
            rint_evt <= set_rint;
            miss_evt <= set_miss;
            if (load_first || load_next) begin
                cap   <= cap_of(rd_desc.neg_size);
                neg_q <= rd_desc.neg_size;
                cnt   <= '0;
                sop_q <= load_first;
            end else if (buf_we) begin
                cnt <= cnt + 1'b1;
            end
            if (adv_idx) idx <= idx_nxt;
        end
    end

    // Next state and outputs
    always_comb begin
        nstate     = state;
        in_ready   = 1'b0;
        rd_addr    = idx;
        wr_en      = 1'b0;
        wr_desc    = '0;
        buf_we     = 1'b0;
        load_first = 1'b0;
        load_next  = 1'b0;
        adv_idx    = 1'b0;
        set_rint   = 1'b0;
        set_miss   = 1'b0;
        wr_desc.sop      = sop_q;
        wr_desc.neg_size = neg_q;
        wr_desc.count    = cnt[LW-1:0];
        unique case (state)
            ST_IDLE: begin
                in_ready = !in_sof;
                if (in_valid && in_sof) begin
                    if (!rx_en) begin
                        nstate = ST_DROP;
                    end else if (!rd_desc.own) begin
                        set_miss = 1'b1;
                        nstate   = ST_DROP;
                    end else begin
                        load_first = 1'b1;
                        nstate     = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    buf_we = 1'b1;
                    if (in_eof)                      nstate = ST_CLOSE;
                    else if ((cnt + 1'b1) == cap)    nstate = ST_NEXT;
                end
            end
            ST_NEXT: begin
                rd_addr = idx_nxt;
                wr_en   = 1'b1;
                adv_idx = 1'b1;
                if (rd_desc.own && !idx_single) begin
                    load_next = 1'b1;
                    nstate    = ST_FILL;
                end else begin
                    wr_desc.buff = 1'b1;
                    wr_desc.oflo = 1'b1;
                    set_rint     = 1'b1;
                    nstate       = ST_DROP;
                end
            end
            ST_CLOSE: begin
                wr_en       = 1'b1;
                wr_desc.eop = 1'b1;
                adv_idx     = 1'b1;
                set_rint    = 1'b1;
                nstate      = ST_IDLE;
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_eof) nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    assign wr_addr  = idx;
    assign buf_idx  = idx;
    assign buf_off  = cnt[LW-1:0];
    assign buf_data = in_data;

    AST_OFF_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (cnt < cap));                                   // R5
    AST_RINT_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        rint_evt |-> $past(wr_en));                                // R6
    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rint_evt, miss_evt}));                           // R3
    AST_MISS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        miss_evt |-> $past(rx_en));                                // R2
    AST_STALL_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !in_ready);                                      // R10
    AST_WB_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(buf_we));                                  // R7
endmodule

// File: rtl/rxr_engine.sv
`timescale 1ns/1ps
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int EW = rxr_pkg::EXP_W,
    parameter int LW = rxr_pkg::LEN_W,
    localparam int AW = (1 << EW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic [7:0]    ring_len,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic          in_ready,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    output logic          buf_we,
    output logic [AW-1:0] buf_idx,
    output logic [LW-1:0] buf_off,
    output logic [7:0]    buf_data,
    output logic          rint_evt,
    output logic          miss_evt
);
    rx_desc_t      rd_desc, wr_desc, host_rd;
    logic [AW-1:0] rd_addr, wr_addr, idx, idx_nxt;
    logic          wr_en, idx_single;
    logic          unused_len_bits;

    assign unused_len_bits = ^ring_len[4:0];
    assign host_rdata      = host_rd;

    rxr_desc_mem #(.AW(AW)) u_mem (
        .clk        (clk),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (rx_desc_t'(host_wdata)),
        .host_rdata (host_rd),
        .eng_we     (wr_en),
        .eng_waddr  (wr_addr),
        .eng_wdata  (wr_desc),
        .eng_raddr  (rd_addr),
        .eng_rdata  (rd_desc)
    );

    rxr_ring_idx #(.EW(EW)) u_idx (
        .ring_exp (ring_len[7:5]),
        .cur      (idx),
        .nxt      (idx_nxt),
        .single   (idx_single)
    );

    rxr_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_ready   (in_ready),
        .rd_desc    (rd_desc),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_desc    (wr_desc),
        .idx_nxt    (idx_nxt),
        .idx_single (idx_single),
        .idx        (idx),
        .buf_we     (buf_we),
        .buf_idx    (buf_idx),
        .buf_off    (buf_off),
        .buf_data   (buf_data),
        .rint_evt   (rint_evt),
        .miss_evt   (miss_evt)
    );
endmodule

// File: tb/tb_rxr_engine.sv
`timescale 1ns/1ps
module tb_rxr_engine;
    logic        clk = 1'b0;
    logic        rst_n, rx_en, in_valid, in_sof, in_eof, in_ready, host_we;
    logic [7:0]  ring_len, in_data, buf_data;
    logic [6:0]  host_addr, buf_idx;
    logic [31:0] host_wdata, host_rdata;
    logic        buf_we, rint_evt, miss_evt;
    logic [11:0] buf_off;

    always #2.5 clk = ~clk;

    rxr_engine dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_len(ring_len),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_off(buf_off), .buf_data(buf_data),
        .rint_evt(rint_evt), .miss_evt(miss_evt)
    );

    int ncheck = 0, nfail = 0;
    bit done = 0;
    logic [31:0] exp_desc [128];
    logic [7:0]  exp_buf [128][64];
    logic [7:0]  act_buf [128][64];
    logic [7:0]  fr [256];
    int exp_idx, cur_exp, exp_rint, exp_miss, act_rint, act_miss, bad_off;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        ncheck++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            ncheck++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // Output monitor, sampled mid-cycle
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (buf_we) begin
                if (buf_off < 64) act_buf[buf_idx][buf_off[5:0]] = buf_data;
                else bad_off++;
            end
            if (rint_evt) act_rint++;
            if (miss_evt) act_miss++;
        end
    end

    function automatic logic [31:0] mk(input bit own, input bit sop, input bit eop,
                                       input bit ovf, input logic [11:0] neg, input int cnt);
        return {own, sop, eop, ovf, ovf, 3'b000, neg, 12'(cnt)};
    endfunction

    function automatic int ring_mask();
        return (1 << cur_exp) - 1;
    endfunction

    task automatic do_reset(input int exp_bits);
        cur_exp  = exp_bits;
        ring_len = {3'(exp_bits), 5'b10101};   // R1: low bits are junk
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        exp_idx = 0;
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1; host_addr = 7'(a); host_wdata = d;
        @(negedge clk);
        host_we = 0;
        exp_desc[a] = d;
    endtask

    task automatic arm(input int a, input bit own, input int cap);
        host_write(a, mk(own, 0, 0, 0, 12'(-cap), 0));
    endtask

    task automatic arm_all(input int cap);
        for (int i = 0; i <= ring_mask(); i++) arm(i, 1, cap);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit s, input bit e, inout int stalls);
        @(negedge clk);
        in_valid = 1; in_data = d; in_sof = s; in_eof = e;
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(posedge clk);
    endtask

    task automatic model(input int n, input bit en, output int st);
        int i, cnt, cap, nx;
        bit sop;
        st = 1;
        if (!en) return;
        i = exp_idx;
        if (!exp_desc[i][31]) begin exp_miss++; return; end
        sop = 1; cnt = 0; cap = 4096 - int'(exp_desc[i][23:12]);
        for (int k = 0; k < n; k++) begin
            exp_buf[i][cnt] = fr[k];
            cnt++;
            if (k == n - 1) begin
                exp_desc[i] = mk(0, sop, 1, 0, exp_desc[i][23:12], cnt);
                exp_rint++;
                exp_idx = (i + 1) & ring_mask();
                return;
            end
            if (cnt == cap) begin
                nx = (i + 1) & ring_mask();
                st++;
                if (exp_desc[nx][31] && nx != i) begin
                    exp_desc[i] = mk(0, sop, 0, 0, exp_desc[i][23:12], cnt);
                    i = nx; exp_idx = nx; sop = 0; cnt = 0;
                    cap = 4096 - int'(exp_desc[i][23:12]);
                end else begin
                    exp_desc[i] = mk(0, sop, 0, 1, exp_desc[i][23:12], cnt);
                    exp_idx = nx;
                    exp_rint++;
                    return;
                end
            end
        end
    endtask

    task automatic verify(input string tag, input int st_act, input int st_exp);
        int mism;
        mism = 0;
        for (int i = 0; i <= ring_mask(); i++) begin
            @(negedge clk);
            host_addr = 7'(i);
            #1;
            chk({tag, " R4 R6 R7 R8 R9 R11"}, $sformatf("desc[%0d]", i), host_rdata, exp_desc[i]);
        end
        for (int i = 0; i < 128; i++)
            for (int j = 0; j < 64; j++)
                if (act_buf[i][j] !== exp_buf[i][j]) mism++;
        chk({tag, " R5"}, "buffer byte mismatches", mism, 0);
        chk({tag, " R5"}, "offsets beyond buffer", bad_off, 0);
        chk({tag, " R6 R8"}, "rint events", act_rint, exp_rint);
        chk({tag, " R2 R3"}, "miss events", act_miss, exp_miss);
        chk({tag, " R10"}, "stall cycles", st_act, st_exp);
    endtask

    task automatic frame(input string tag, input int n, input bit en);
        int st, st_exp;
        st = 0;
        rx_en = en;
        for (int k = 0; k < n; k++) fr[k] = 8'($urandom);
        for (int k = 0; k < n; k++) send_byte(fr[k], k == 0, k == n - 1, st);
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (4) @(negedge clk);
        model(n, en, st_exp);
        verify(tag, st, st_exp);
        rx_en = 1;
    endtask

    initial begin
        int st;
        void'($urandom(32'd7741));
        rst_n = 0; rx_en = 1; ring_len = 0; in_valid = 0; in_data = 0;
        in_sof = 0; in_eof = 0; host_we = 0; host_addr = 0; host_wdata = 0;
        exp_rint = 0; exp_miss = 0; act_rint = 0; act_miss = 0; bad_off = 0;
        for (int i = 0; i < 128; i++) begin
            exp_desc[i] = 0;
            for (int j = 0; j < 64; j++) begin exp_buf[i][j] = 0; act_buf[i][j] = 0; end
        end

        do_reset(2);
        @(negedge clk); #1;
        chk("R10", "in_ready after reset", in_ready, 1);
        chk("R6", "rint after reset", rint_evt, 0);
        chk("R3", "miss after reset", miss_evt, 0);
        chk("R5", "buf_we after reset", buf_we, 0);

        // R11: host port readback
        host_write(5, 32'h8012_3456);
        @(negedge clk); host_addr = 7'd5; #1;
        chk("R11", "host readback", host_rdata, 32'h8012_3456);

        // Ring of four, capacity four
        arm_all(4);
        frame("fits", 3, 1);                  // R6
        arm_all(4);
        frame("exact fill", 4, 1);            // R6: end byte fills the buffer
        arm_all(4);
        frame("chain wrap", 10, 1);           // R7 and R1: uses 2,3,0
        chk("R1", "index after wrap", exp_idx, 1);

        arm(exp_idx, 0, 4);
        frame("miss", 6, 1);                  // R3
        frame("disabled", 5, 0);              // R2

        arm_all(2);
        arm((exp_idx + 1) & ring_mask(), 0, 2);
        frame("overflow", 7, 1);              // R8

        arm_all(1);
        frame("capacity one", 3, 1);          // R5

        // R10: stray byte outside a frame is swallowed without stall
        st = 0;
        send_byte(8'hA5, 0, 0, st);
        @(negedge clk); in_valid = 0;
        repeat (3) @(negedge clk);
        verify("stray", st, 0);

        // R8: ring of a single descriptor
        do_reset(0);
        arm(0, 1, 3);
        frame("single ring", 5, 1);
        chk("R1", "index in single ring", exp_idx, 0);

        // Random traffic on a ring of eight
        do_reset(3);
        arm_all(8);
        for (int it = 0; it < 60; it++) begin
            if ($urandom_range(3) == 0)
                for (int i = 0; i < 8; i++)
                    arm(i, $urandom_range(7) != 0, 1 + $urandom_range(11));
            frame("random", 1 + $urandom_range(29), $urandom_range(9) != 0);
        end

        finish_run();
    end
endmodule